// File: doc/BRIEF.md
# All-Channel Zero-Detect Mute Controller

This block produces an active-high mute request for off-chip muting circuitry in a six-channel audio output path. Two things drive the request. The first is a set of system conditions: reset, a power state other than running, a clock ratio flagged as invalid, and an output warm-up window that has not yet run out. The second is data-driven: the request also asserts once every channel has carried a long run of consecutive zero samples.

All six channels share one sample strobe. On each strobe, each channel's 24-bit two's-complement sample either extends that channel's zero run or clears it. The warm-up window counts sample strobes while the power state is running and the clock ratio is valid. Any loss of either condition restarts it.

The block also gates the sample bus it forwards downstream. While the output is disabled, the forwarded samples are forced to zero, which puts the output in the zero-data state during clock-ratio changes and during warm-up. All outputs are registered and change only on the rising clock edge.

Top module: `zero_mute_ctrl`

## Requirements
- R1: While rst_ni is low, mute_o is 1, audio_en_o is 0 and samples_o is all zero. Reset is asynchronous.
- R2: The power state input is encoded as off = 0, ramp-up = 1, run = 2, ramp-down = 3. At any edge where it is not run, mute_o becomes 1 and audio_en_o becomes 0, and the warm-up count returns to zero.
- R3: At any edge where ratio_ok_i is 0, mute_o becomes 1, audio_en_o becomes 0, samples_o becomes zero and the warm-up count returns to zero.
- R4: audio_en_o rises at the edge that accepts the 2000th sample strobe counted while the power state is run and ratio_ok_i is 1 without interruption. Until then mute_o stays 1.
- R5: With the output enabled, mute_o becomes 1 at the edge that accepts a strobe after which every channel has seen 512 consecutive zero samples. Strobes are counted per channel, and the count saturates.
- R6: A strobe carrying a nonzero sample on any channel clears mute_o at that same edge, unless a system condition holds. That channel then needs 512 new zero strobes before mute_o asserts again.
- R7: While enabled, samples_o takes samples_i on each strobe and holds between strobes. Channel c occupies bits [24*c+23 : 24*c]. While disabled, samples_o is zero.
- R8: Samples presented without sample_valid_i advance neither the zero runs nor the warm-up count, and do not change samples_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample period for all channels |
| samples_i | input | 144 | Six 24-bit samples, channel 0 in the low bits |
| ratio_ok_i | input | 1 | Clock ratio is valid |
| pwr_state_i | input | 2 | Power state: 0 off, 1 ramp-up, 2 run, 3 ramp-down |
| mute_o | output | 1 | Active-high mute request |
| audio_en_o | output | 1 | Output enabled (warm-up done and system running) |
| samples_o | output | 144 | Forwarded samples, zero while disabled |

## Verification
Each output is a single register fed from the next-state value of the counters. A strobe, a data value, a power state or a ratio flag presented before a rising edge is therefore reflected on all three outputs right after that same edge, with no extra latency. The bench changes inputs one time unit after each rising edge and compares all outputs against its arithmetic model one time unit after the following edge. The 1999th and 2000th warm-up strobes and the 511th and 512th zero strobes are checked individually, both for a common start and for a staggered start.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  typedef enum logic [1:0] {
    PWR_OFF       = 2'd0,
    PWR_RAMP_UP   = 2'd1,
    PWR_RUN       = 2'd2,
    PWR_RAMP_DOWN = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/zero_run_cnt.sv
module zero_run_cnt #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 512
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sat_next_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] SAT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (strobe_i) begin
      if (sample_i != '0) cnt_d = '0;
      else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign sat_next_o = (cnt_d == SAT);
endmodule

// File: rtl/warmup_timer.sv
module warmup_timer #(
  parameter int DLY = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic strobe_i,
  output logic done_next_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                       cnt_d = '0;
    else if (strobe_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_next_o = (cnt_d == LAST);
endmodule

// File: rtl/zero_mute_ctrl.sv
module zero_mute_ctrl
  import zmute_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 512,
  parameter int WARM_DLY = 2000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  input  logic                       ratio_ok_i,
  input  logic [1:0]                 pwr_state_i,
  output logic                       mute_o,
  output logic                       audio_en_o,
  output logic [NUM_CH*SAMPLE_W-1:0] samples_o
);
  localparam int BUS_W = NUM_CH * SAMPLE_W;

  logic [NUM_CH-1:0] ch_sat_next;
  logic              run;
  logic              warm_done_next;
  logic              en_d;
  logic              data_mute_d;
  logic              data_mute_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    zero_run_cnt #(
      .SAMPLE_W(SAMPLE_W),
      .RUN_LEN (ZERO_RUN)
    ) i_zrun (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_i  (sample_valid_i),
      .sample_i  (samples_i[g*SAMPLE_W +: SAMPLE_W]),
      .sat_next_o(ch_sat_next[g])
    );
  end

  assign run = ratio_ok_i && (pwr_state_i == PWR_RUN);

  warmup_timer #(
    .DLY(WARM_DLY)
  ) i_warm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .strobe_i   (sample_valid_i),
    .done_next_o(warm_done_next)
  );

  assign en_d        = run && warm_done_next;
  assign data_mute_d = &ch_sat_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_o      <= 1'b1;
      audio_en_o  <= 1'b0;
      data_mute_q <= 1'b0;
      samples_o   <= '0;
    end else begin
      mute_o      <= !en_d || data_mute_d;
      audio_en_o  <= en_d;
      data_mute_q <= data_mute_d;
      if (!en_d)               samples_o <= BUS_W'(0);
      else if (sample_valid_i) samples_o <= samples_i;
    end
  end
endmodule

// File: rtl/zero_mute_chk.sv
module zero_mute_chk
  import zmute_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sample_valid_i,
  input logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  input logic                       ratio_ok_i,
  input logic [1:0]                 pwr_state_i,
  input logic                       mute_o,
  input logic                       audio_en_o,
  input logic [NUM_CH*SAMPLE_W-1:0] samples_o,
  input logic                       data_mute_q
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (mute_o && !audio_en_o && samples_o == '0);
    end
  end

  a_r2_pwr_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i != PWR_RUN) |=> (mute_o && !audio_en_o));

  a_r3_ratio_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_ok_i |=> (mute_o && !audio_en_o && samples_o == '0));

  a_r4_en_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(audio_en_o) |-> $past(sample_valid_i));

  a_r5_mute_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_mute_q) |-> ($past(sample_valid_i) && $past(samples_i) == '0));

  a_r6_nonzero_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && samples_i != '0) |=> !data_mute_q);

  a_r7_gated_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !audio_en_o |-> samples_o == '0);

  a_r8_no_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(data_mute_q));
endmodule

bind zero_mute_ctrl zero_mute_chk #(
  .NUM_CH  (NUM_CH),
  .SAMPLE_W(SAMPLE_W)
) i_zero_mute_chk (.*);

// File: tb/test_zero_mute_ctrl.sv
module test_zero_mute_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int SW   = 24;
  localparam int BW   = NCH * SW;
  localparam int ZRUN = 512;
  localparam int WARM = 2000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid;
  logic [BW-1:0] samples;
  logic          ratio_ok;
  logic [1:0]    pwr;
  logic          mute;
  logic          en;
  logic [BW-1:0] samp_o;

  int n_chk  = 0;
  int n_fail = 0;

  int            zc [NCH];
  int            wc;
  bit            exp_en;
  bit            exp_mute;
  logic [BW-1:0] exp_samp;

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_mute_ctrl i_zero_mute_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sample_valid_i(valid),
    .samples_i     (samples),
    .ratio_ok_i    (ratio_ok),
    .pwr_state_i   (pwr),
    .mute_o        (mute),
    .audio_en_o    (en),
    .samples_o     (samp_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) zc[c] = 0;
    wc = 0; exp_en = 0; exp_mute = 1; exp_samp = '0;
  endtask

  task automatic drive(input bit v, input logic [NCH-1:0] nz);
    valid = v;
    for (int c = 0; c < NCH; c++) begin
      logic [SW-1:0] x;
      x = SW'($urandom);
      if (x == '0) x = 1;
      samples[c*SW +: SW] = nz[c] ? x : '0;
    end
  endtask

  task automatic cycle(input string tag);
    bit run, dm;
    @(posedge clk);
    run = (pwr == 2'd2) && ratio_ok;
    if (valid)
      for (int c = 0; c < NCH; c++)
        zc[c] = (samples[c*SW +: SW] == '0) ? ((zc[c] < ZRUN) ? zc[c] + 1 : ZRUN) : 0;
    if (!run) wc = 0;
    else if (valid && wc < WARM) wc++;
    exp_en = run && (wc == WARM);
    dm = 1;
    for (int c = 0; c < NCH; c++) if (zc[c] != ZRUN) dm = 0;
    exp_mute = !exp_en || dm;
    if (!exp_en) exp_samp = '0;
    else if (valid) exp_samp = samples;
    #1;
    chk(mute == exp_mute, tag, "mute_o", BW'(mute), BW'(exp_mute));
    chk(en == exp_en, tag, "audio_en_o", BW'(en), BW'(exp_en));
    chk(samp_o == exp_samp, tag, "samples_o", samp_o, exp_samp);
  endtask

  // Strobe with nonzero data until warm-up count reaches target
  task automatic warm_to(input int target, input string tag);
    int i = 0;
    while (wc < target) begin
      drive((i % 3) != 2, '1);
      cycle(tag);
      i++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; valid = 0; samples = '0; ratio_ok = 0; pwr = 2'd0;
    model_reset();
    #(3*CLK_PERIOD + 2);
    chk(mute == 1'b1, "R1", "mute_o in reset", BW'(mute), BW'(1));
    chk(en == 1'b0, "R1", "audio_en_o in reset", BW'(en), BW'(0));
    chk(samp_o == '0, "R1", "samples_o in reset", samp_o, '0);
    @(posedge clk); #1;
    rst_n = 1;

    // R2: ramp-up and off keep mute
    pwr = 2'd1; ratio_ok = 1;
    for (int i = 0; i < 20; i++) begin drive(1, '1); cycle("R2"); end
    pwr = 2'd0;
    for (int i = 0; i < 5; i++) begin drive(1, '1); cycle("R2"); end

    // R4 and R8: warm-up with gaps in the strobe
    pwr = 2'd2;
    warm_to(WARM - 1, "R4");
    drive(0, '1); cycle("R8");
    chk(en == 1'b0, "R8", "no advance without strobe", BW'(en), BW'(0));
    drive(1, '1); cycle("R4");
    chk(en == 1'b1 && mute == 1'b0, "R4", "enable at 2000th strobe", BW'({en, mute}), BW'(2'b10));

    // R7: pass-through and hold
    for (int i = 0; i < 200; i++) begin
      drive(($urandom % 2) == 1, NCH'($urandom));
      cycle("R7");
    end
    drive(1, '1); cycle("R7");
    begin
      logic [BW-1:0] held;
      held = samp_o;
      drive(0, '1); cycle("R8");
      chk(samp_o == held, "R8", "samples_o held without strobe", samp_o, held);
    end

    // R5: common start of zero run
    for (int i = 0; i < ZRUN - 1; i++) begin drive(1, '0); cycle("R5"); end
    chk(mute == 1'b0, "R5", "511 zero strobes", BW'(mute), BW'(0));
    drive(1, '0); cycle("R5");
    chk(mute == 1'b1, "R5", "512 zero strobes", BW'(mute), BW'(1));

    // R8: unstrobed nonzero data ignored while muted
    for (int i = 0; i < 5; i++) begin drive(0, '1); cycle("R8"); end
    chk(mute == 1'b1, "R8", "mute kept without strobe", BW'(mute), BW'(1));

    // R6: single-channel nonzero releases at once
    drive(1, 6'b100000); cycle("R6");
    chk(mute == 1'b0, "R6", "release on ch5 nonzero", BW'(mute), BW'(0));

    // R5/R6: staggered start, channel 3 restarts later
    for (int i = 0; i < 100; i++) begin drive(1, '0); cycle("R6"); end
    drive(1, 6'b001000); cycle("R6");
    for (int i = 0; i < ZRUN - 1; i++) begin drive(1, '0); cycle("R5"); end
    chk(mute == 1'b0, "R5", "staggered 511", BW'(mute), BW'(0));
    drive(1, '0); cycle("R5");
    chk(mute == 1'b1, "R5", "staggered 512", BW'(mute), BW'(1));

    // R3: ratio invalid for one edge
    drive(1, '1); cycle("R6");
    ratio_ok = 0; drive(1, '1); cycle("R3");
    chk(mute == 1'b1 && en == 1'b0 && samp_o == '0, "R3", "ratio invalid",
        BW'({mute, en}), BW'(2'b10));
    ratio_ok = 1;
    warm_to(WARM - 1, "R3");
    chk(en == 1'b0, "R3", "warm-up restarted", BW'(en), BW'(0));
    drive(1, '1); cycle("R3");
    chk(en == 1'b1, "R3", "re-enabled", BW'(en), BW'(1));

    // R2: ramp-down
    pwr = 2'd3; drive(1, '1); cycle("R2");
    chk(mute == 1'b1 && en == 1'b0, "R2", "ramp-down mutes", BW'({mute, en}), BW'(2'b10));
    for (int i = 0; i < 10; i++) begin drive(1, '1); cycle("R2"); end
    pwr = 2'd2;
    for (int i = 0; i < 30; i++) begin drive(1, '1); cycle("R2"); end

    // R1: reset mid-run
    rst_n = 0; #1;
    model_reset();
    chk(mute == 1'b1 && en == 1'b0 && samp_o == '0, "R1", "async reset",
        BW'({mute, en}), BW'(2'b10));
    @(posedge clk); #1;
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin drive(1, '1); cycle("R1"); end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule